// File: doc/BRIEF.md
# Serial Receive Character Queue with Threshold and Overrun

This block sits between the deserializer of a serial port and the register interface that software reads. Each received character enters a sixteen-entry first-in first-out queue with three per-character error flags: parity, framing and line break. A register read of the data location pops the oldest character. A read of the status location clears the sticky overrun flag. When the queue is switched off it behaves as a single holding register.

A control byte written on a strobe sets the queue mode and the fill threshold, and can request an immediate flush. The outputs tell the interrupt logic four things: whether any character is waiting, whether the fill level has reached the chosen threshold, whether a character was lost, and whether any error-tagged character is still queued.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the queue is empty, the queue mode is off, the threshold select is 00, and every output including the status byte reads zero.
- R2: With the queue mode on it holds up to 16 characters. With the queue mode off it holds at most one character. `data_ready` is high whenever at least one character is held.
- R3: Characters leave in arrival order, and `head_char` shows the oldest held character (zero when empty). A pop strobe while empty has no effect.
- R4: `at_trigger` is high while the fill level is at or above the threshold. With the queue mode on, select 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With the queue mode off the threshold is 1.
- R5: In the control byte, bit 0 turns the queue mode on, bit 1 requests a flush, and bits 7:6 select the threshold. A write that changes bit 0 also empties the queue.
- R6: A flush empties the queue on the next clock edge and keeps the written mode and threshold. It is self-clearing. A character arriving in the same cycle is discarded and does not raise overrun.
- R7: A character that arrives while the queue is at capacity, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` stays set until a status read. If a discard and a status read happen in the same cycle, the flag stays set.
- R8: A push and a pop in the same cycle, including when the queue is at capacity, leave the fill level unchanged and do not raise overrun.
- R9: The status byte carries data-ready in bit 0, overrun in bit 1, and the head character's parity, framing and break flags in bits 2, 3 and 4. Bits 6:5 read zero and bit 7 is the error-in-queue flag. The head flags read zero when the queue is empty.
- R10: `err_in_fifo` is high while at least one held character carries any of its three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_byte | input | 8 | Control byte: enable bit 0, flush bit 1, threshold select bits 7:6 |
| rx_valid | input | 1 | A character arrives from the deserializer |
| rx_char | input | 8 | Arriving character |
| rx_par_err | input | 1 | Parity error flag of the arriving character |
| rx_frm_err | input | 1 | Framing error flag of the arriving character |
| rx_brk | input | 1 | Line break flag of the arriving character |
| data_pop | input | 1 | Data register read: remove the head character |
| stat_rd | input | 1 | Status register read: clears overrun |
| head_char | output | 8 | Oldest held character |
| status | output | 8 | Line status byte |
| data_ready | output | 1 | At least one character held |
| at_trigger | output | 1 | Fill level at or above the threshold |
| overrun | output | 1 | Sticky lost-character flag |
| err_in_fifo | output | 1 | Some held character carries an error flag |

## Verification
The hardest cases to reach are the ones at full capacity. One is a push that coincides with a pop at level 16. Another is a discard that lands in the same cycle as a status read. A third is an error-tagged entry sitting behind clean ones, so the summary flag must outlive the head flags. Directed sequences fill the queue to exactly 16 and then apply each of these coincidences. Random traffic with pushes weighted above pops keeps the queue near full for long stretches. Occasional random control writes toggle the mode and flush mid-traffic, which also exercises the single-register mode at capacity 1.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    // control byte bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_CLR_BIT  = 1;
    localparam int CTL_TRIG_LSB = 6;

    // status byte bit positions
    localparam int ST_READY = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_PAR   = 2;
    localparam int ST_FRM   = 3;
    localparam int ST_BRK   = 4;
    localparam int ST_ERRQ  = 7;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'b00,
        TRIG_QUARTER = 2'b01,
        TRIG_HALF    = 2'b10,
        TRIG_HIGH    = 2'b11
    } rxq_trig_e;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] ch;
    } rxq_entry_t;

    typedef struct packed {
        logic      en;
        rxq_trig_e trig;
    } rxq_cfg_t;

    function automatic logic entry_has_err(rxq_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction

    // threshold scales with depth: 1, depth/4, depth/2, depth-2
    function automatic int unsigned trig_level(logic en, rxq_trig_e sel, int unsigned depth);
        if (!en) return 1;
        case (sel)
            TRIG_ONE:     return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
`timescale 1ns/1ps
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_byte,
    output rxq_cfg_t   cfg_q,
    output logic       flush
);
    logic mode_change;

    always_comb begin
        mode_change = cfg_byte[CTL_EN_BIT] != cfg_q.en;
        flush       = cfg_we && (cfg_byte[CTL_CLR_BIT] || mode_change);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{en: 1'b0, trig: TRIG_ONE};
        end else if (cfg_we) begin
            cfg_q.en   <= cfg_byte[CTL_EN_BIT];
            cfg_q.trig <= rxq_trig_e'(cfg_byte[CTL_TRIG_LSB +: 2]);
        end
    end

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              flush,
    input  logic              push_req,
    input  rxq_entry_t        wr_entry,
    input  logic              pop_req,
    output rxq_entry_t        head,
    output logic [$clog2(DEPTH+1)-1:0] count_q,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              dropped
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_ON  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_OFF = CW'(1);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    rxq_entry_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   cap;
    logic            room;

    always_comb begin
        cap     = en ? CAP_ON : CAP_OFF;
        room    = count_q < cap;
        pop_ok  = pop_req && (count_q != '0) && !flush;
        push_ok = push_req && !flush && (room || pop_ok);
        dropped = push_req && !flush && !room && !pop_ok;
        head    = (count_q != '0) ? mem[rd_ptr] : '0;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R2
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= cap);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> count_q == '0);

    // R8
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(count_q));

endmodule

// File: rtl/rxq_errtrack.sv
`timescale 1ns/1ps
module rxq_errtrack #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push_ok,
    input  logic push_err,
    input  logic pop_ok,
    input  logic pop_err,
    output logic err_any
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] err_cnt;
    logic          inc, dec;

    always_comb begin
        inc     = push_ok && push_err;
        dec     = pop_ok && pop_err;
        err_any = err_cnt != '0;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) err_cnt <= '0;
        else              err_cnt <= err_cnt + CW'(inc) - CW'(dec);
    end

    // R10
    err_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> err_cnt != '0);

endmodule

// File: rtl/rxq_status.sv
`timescale 1ns/1ps
module rxq_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  rxq_cfg_t   cfg,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  rxq_entry_t head,
    input  logic       dropped,
    input  logic       stat_rd,
    input  logic       err_any,
    output logic [7:0] status,
    output logic       data_ready,
    output logic       at_trigger,
    output logic       overrun
);
    int unsigned level;

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (dropped) overrun <= 1'b1;
        else if (stat_rd) overrun <= 1'b0;
    end

    always_comb begin
        level      = trig_level(cfg.en, cfg.trig, DEPTH);
        data_ready = count != '0;
        at_trigger = 32'(count) >= level;
        status           = '0;
        status[ST_READY] = data_ready;
        status[ST_OVR]   = overrun;
        status[ST_PAR]   = head.par;
        status[ST_FRM]   = head.frm;
        status[ST_BRK]   = head.brk;
        status[ST_ERRQ]  = err_any;
    end

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        dropped |=> overrun);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !stat_rd) |=> overrun);

endmodule

// File: rtl/rx_char_fifo.sv
`timescale 1ns/1ps
module rx_char_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_byte,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       data_pop,
    input  logic       stat_rd,
    output logic [7:0] head_char,
    output logic [7:0] status,
    output logic       data_ready,
    output logic       at_trigger,
    output logic       overrun,
    output logic       err_in_fifo
);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_cfg_t   cfg_q;
    logic       flush;
    rxq_entry_t wr_entry, head;
    logic [CW-1:0] count;
    logic       push_ok, pop_ok, dropped;

    always_comb begin
        wr_entry = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err, ch: rx_char};
        head_char = head.ch;
    end

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_byte (cfg_byte),
        .cfg_q    (cfg_q),
        .flush    (flush)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_q.en),
        .flush    (flush),
        .push_req (rx_valid),
        .wr_entry (wr_entry),
        .pop_req  (data_pop),
        .head     (head),
        .count_q  (count),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .dropped  (dropped)
    );

    rxq_errtrack #(.DEPTH(DEPTH)) u_err (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push_ok  (push_ok),
        .push_err (entry_has_err(wr_entry)),
        .pop_ok   (pop_ok),
        .pop_err  (entry_has_err(head)),
        .err_any  (err_in_fifo)
    );

    rxq_status #(.DEPTH(DEPTH)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .count      (count),
        .head       (head),
        .dropped    (dropped),
        .stat_rd    (stat_rd),
        .err_any    (err_in_fifo),
        .status     (status),
        .data_ready (data_ready),
        .at_trigger (at_trigger),
        .overrun    (overrun)
    );

    // R10
    err_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
        err_in_fifo |-> data_ready);

endmodule

// File: tb/test_rx_char_fifo.sv
`timescale 1ns/1ps
module test_rx_char_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic       data_pop = 1'b0, stat_rd = 1'b0;
    logic [7:0] head_char, status;
    logic       data_ready, at_trigger, overrun, err_in_fifo;

    int    n_chk = 0;
    int    n_err = 0;
    string phase = "R1";

    // model: entries packed {brk, frm, par, ch}
    logic [10:0] mq[$];
    logic        m_en = 1'b0;
    logic [1:0]  m_trig = 2'b00;
    logic        m_ovr = 1'b0;

    always #10 clk = ~clk;

    rx_char_fifo i_rx_char_fifo (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_byte(cfg_byte),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .data_pop(data_pop),
        .stat_rd(stat_rd), .head_char(head_char), .status(status),
        .data_ready(data_ready), .at_trigger(at_trigger), .overrun(overrun),
        .err_in_fifo(err_in_fifo)
    );

    task automatic chk(string fld, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", phase, fld, act, exp);
        end
    endtask

    function automatic int m_level();
        if (!m_en) return 1;
        case (m_trig)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic m_err_any();
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all();
        logic [10:0] h;
        logic        dr;
        h  = (mq.size() != 0) ? mq[0] : 11'h0;
        dr = mq.size() != 0;
        chk("R9 status", status, {m_err_any(), 2'b00, h[10], h[9], h[8], m_ovr, dr});
        chk("R3 head_char", head_char, h[7:0]);
        chk("R4 at_trigger", {7'b0, at_trigger}, {7'b0, 1'(mq.size() >= m_level())});
        chk("R7 overrun", {7'b0, overrun}, {7'b0, m_ovr});
        chk("R10 err_in_fifo", {7'b0, err_in_fifo}, {7'b0, m_err_any()});
        chk("R2 data_ready", {7'b0, data_ready}, {7'b0, dr});
    endtask

    task automatic cyc(logic v, logic [10:0] d, logic p, logic sr, logic we, logic [7:0] cb);
        logic flush, pe, drop;
        int   cap, sz;
        rx_valid = v;
        {rx_brk, rx_frm_err, rx_par_err, rx_char} = d;
        data_pop = p; stat_rd = sr; cfg_we = we; cfg_byte = cb;
        @(posedge clk);
        flush = we && (cb[1] || (cb[0] != m_en));
        pe    = p && (mq.size() != 0) && !flush;
        cap   = m_en ? 16 : 1;
        sz    = mq.size();
        drop  = 1'b0;
        if (flush) mq.delete();
        else begin
            if (pe) void'(mq.pop_front());
            if (v) begin
                if (sz < cap || pe) mq.push_back(d);
                else drop = 1'b1;
            end
        end
        if (we) begin m_en = cb[0]; m_trig = cb[7:6]; end
        m_ovr = drop ? 1'b1 : (sr ? 1'b0 : m_ovr);
        #1;
        rx_valid = 0; data_pop = 0; stat_rd = 0; cfg_we = 0;
        check_all();
    endtask

    task automatic push(logic [10:0] d);
        cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic pop();
        cyc(1'b0, 11'h0, 1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h1badcafe));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        phase = "R1";
        check_all();

        // R2: disabled mode holds one character; second is lost
        phase = "R2";
        push(11'h011);
        push(11'h022);
        cyc(1'b0, 11'h0, 1'b0, 1'b1, 1'b0, 8'h00);   // status read clears overrun
        pop();
        pop();                                        // R3: pop on empty ignored

        // R5: turn queue mode on, select 14
        phase = "R5";
        cyc(1'b0, 11'h0, 1'b0, 1'b0, 1'b1, 8'hC1);
        for (int i = 0; i < 16; i++) push(11'(8'h40 + i) | ((i == 5) ? 11'h100 : 11'h0));
        // R7: full, discard coinciding with status read keeps overrun set
        phase = "R7";
        cyc(1'b1, 11'h0AA, 1'b0, 1'b1, 1'b0, 8'h00);
        cyc(1'b0, 11'h0, 1'b0, 1'b1, 1'b0, 8'h00);
        // R8: push and pop together at capacity
        phase = "R8";
        cyc(1'b1, 11'h4BB, 1'b1, 1'b0, 1'b0, 8'h00);
        // R3 / R10: drain in order, error entries tracked
        phase = "R10";
        for (int i = 0; i < 17; i++) pop();

        // R4: every threshold, filled through a flush that keeps the mode
        phase = "R4";
        for (int t = 0; t < 4; t++) begin
            cyc(1'b0, 11'h0, 1'b0, 1'b0, 1'b1, {2'(t), 4'b0000, 2'b11});
            for (int i = 0; i < 15; i++) push(11'(8'h80 + i));
        end
        // R6: flush with simultaneous push discards it, no overrun
        phase = "R6";
        cyc(1'b1, 11'h255, 1'b0, 1'b0, 1'b1, 8'h43);
        push(11'h033);
        // R5: clearing the enable bit empties and drops to one entry
        phase = "R5";
        cyc(1'b0, 11'h0, 1'b0, 1'b0, 1'b1, 8'h80);
        push(11'h044);
        push(11'h055);

        // random traffic
        phase = "RAND";
        for (int n = 0; n < 4000; n++) begin
            logic [10:0] d;
            logic        we;
            logic [7:0]  cb;
            d  = {($urandom_range(7) == 0), ($urandom_range(7) == 0),
                  ($urandom_range(7) == 0), 8'($urandom)};
            we = ($urandom_range(59) == 0);
            cb = 8'($urandom);
            if ($urandom_range(3) != 0) cb[0] = m_en;
            cyc(($urandom_range(99) < 60), d, ($urandom_range(99) < 38),
                ($urandom_range(9) == 0), we, cb);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule